// File: doc/BRIEF.md
# Zig-Zag Reorder and Zero-Run Coder

This block takes the quantized coefficients of 8x8 sub-blocks, one word per accepted cycle in raster order (index 0 to 63, row by row). It stores each sub-block already permuted into zig-zag position, then walks that store in order. For every non-zero coefficient it emits one item: the number of zero coefficients that came before it in scan order, and the coefficient itself. Two 64-entry banks alternate, so the next sub-block can be written while the previous one is being scanned.

Each item also carries an end flag and the index of the sub-block within its macroblock. Indices 0 to 3 are luminance, 4 is U and 5 is V. The last non-zero item of a sub-block carries the end flag. A sub-block with no non-zero coefficient yields one bare end item. The scan of a sub-block stops after its last non-zero coefficient, and it never takes more than 64 cycles.

Top module: `zz_run_coder`

## Requirements
- R1: While reset is low, and after it is released, the outputs are idle (as in R8). The sub-block index of the first sub-block after reset is 0.
- R2: A coefficient is taken on each rising edge with `in_vld` high. Exactly 64 such words form one sub-block, and any number of idle cycles may occur between them.
- R3: Items of a sub-block leave in zig-zag order. The scan visits raster positions 0, 1, 8, 16, 9, 2, 3, 10, 17, 24, ... and ends at 63.
- R4: Only non-zero coefficients produce a pair. `out_val` equals the input word, and `out_eob` is 0 except on the last pair.
- R5: `out_run` counts the zero coefficients in scan order between the previous non-zero coefficient of the same sub-block (or the sub-block start) and this one. The count restarts at every sub-block.
- R6: The final non-zero pair of a sub-block has `out_eob`=1. An all-zero sub-block emits exactly one item with `out_eob`=1, `out_run`=0 and `out_val`=0.
- R7: `out_blk` follows the sequence 0,1,2,3,4,5,0,... over successive sub-blocks. It is constant across all items of one sub-block.
- R8: In a cycle without an item, `out_stb` is 0, `out_val` and `out_run` are all ones, `out_eob` is 0 and `out_blk` is all ones.
- R9: Sub-blocks may arrive back to back with `in_vld` high every cycle, and no item is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input coefficient valid |
| in_coef | input | CW | Quantized coefficient, raster order |
| out_stb | output | 1 | One-cycle strobe per emitted item |
| out_run | output | 6 | Zero count preceding the coefficient |
| out_val | output | CW | Non-zero coefficient value |
| out_eob | output | 1 | Last item of the sub-block |
| out_blk | output | 3 | Sub-block index 0 to 5 |

## Verification
The hardest case to reach is the point where the bank swap meets the early end of a scan. This happens when a new sub-block streams in every cycle while the one being scanned ends on its very last position, or ends at once because it is all zero. The stimulus gets there with long back-to-back bursts at full rate. These bursts mix random sparse blocks with directed blocks that are all zero, fully dense, or non-zero only at raster 63. Gapped input runs in between. A mid-run reset checks that the sub-block index restarts.

// File: rtl/zz_run_coder.sv
module zz_run_coder #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [CW-1:0] in_coef,
  output logic          out_stb,
  output logic [5:0]    out_run,
  output logic [CW-1:0] out_val,
  output logic          out_eob,
  output logic [2:0]    out_blk
);
  localparam int N = 64;

  function automatic logic [5:0] zz_pos(input logic [5:0] idx);
    int r, c, d, b, o;
    r = int'(idx[5:3]);
    c = int'(idx[2:0]);
    d = r + c;
    if (d < 8) begin
      b = d * (d + 1) / 2;
      o = d[0] ? r : c;
    end else begin
      b = N - (15 - d) * (16 - d) / 2;
      o = d[0] ? r - (d - 7) : c - (d - 7);
    end
    return 6'(b + o);
  endfunction

  logic [CW-1:0] mem [2][N];
  logic [5:0] wcnt, rcnt, run;
  logic       wsel, rsel;
  logic [1:0] full, any_nz;
  logic [5:0] last_nz [2];
  logic [2:0] blk_of [2];
  logic [2:0] wblk;

  wire [5:0]    wpos = zz_pos(wcnt);
  wire          in_nz = in_coef != '0;
  wire [CW-1:0] cur = mem[rsel][rcnt];
  wire          scan = full[rsel];
  wire          done = !any_nz[rsel] || rcnt == last_nz[rsel];

  always_ff @(posedge clk)
    if (in_vld) mem[wsel][wpos] <= in_coef;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0; rcnt <= '0; run <= '0;
      wsel <= 1'b0; rsel <= 1'b0; full <= '0; any_nz <= '0;
      last_nz[0] <= '0; last_nz[1] <= '0;
      blk_of[0] <= '0; blk_of[1] <= '0; wblk <= '0;
      out_stb <= 1'b0; out_run <= '1; out_val <= '1; out_eob <= 1'b0; out_blk <= '1;
    end else begin
      out_stb <= 1'b0; out_run <= '1; out_val <= '1; out_eob <= 1'b0; out_blk <= '1;
      if (scan) begin
        if (!any_nz[rsel]) begin
          out_stb <= 1'b1; out_run <= '0; out_val <= '0; out_eob <= 1'b1;
          out_blk <= blk_of[rsel];
        end else if (cur != '0) begin
          out_stb <= 1'b1; out_run <= run; out_val <= cur; out_eob <= done;
          out_blk <= blk_of[rsel];
          run <= '0;
        end else begin
          run <= run + 6'd1;
        end
        if (done) begin
          full[rsel] <= 1'b0;
          rsel <= ~rsel;
          rcnt <= '0;
          run  <= '0;
        end else begin
          rcnt <= rcnt + 6'd1;
        end
      end
      if (in_vld) begin
        if (in_nz && (wcnt == '0 || !any_nz[wsel] || wpos > last_nz[wsel]))
          last_nz[wsel] <= wpos;
        any_nz[wsel] <= (wcnt == '0) ? in_nz : (any_nz[wsel] | in_nz);
        wcnt <= wcnt + 6'd1;
        if (wcnt == 6'(N - 1)) begin
          full[wsel]   <= 1'b1;
          blk_of[wsel] <= wblk;
          wblk <= (wblk == 3'd5) ? 3'd0 : wblk + 3'd1;
          wsel <= ~wsel;
        end
      end
    end
  end

  // R9
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> !full[wsel]);

  // R4
  pair_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb && !out_eob |-> out_val != '0);

  // R7
  blk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |-> out_blk <= 3'd5);

  // R6
  bare_eob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb && out_val == '0 |-> out_eob && out_run == '0);

  // R3
  scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan && any_nz[rsel] |-> rcnt <= last_nz[rsel]);
endmodule

// File: tb/zz_run_coder_tb.sv
module zz_run_coder_tb_top;
  localparam int CW = 8;
  localparam int IW = 1 + 3 + 6 + CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [CW-1:0] in_coef = '0;
  logic out_stb, out_eob;
  logic [5:0] out_run;
  logic [CW-1:0] out_val;
  logic [2:0] out_blk;

  int total = 0;
  int bad = 0;
  int order [64];
  int bblk = 0;
  logic [IW-1:0] expq [$];

  always #4 clk = ~clk;

  zz_run_coder #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_coef(in_coef),
    .out_stb(out_stb), .out_run(out_run), .out_val(out_val),
    .out_eob(out_eob), .out_blk(out_blk)
  );

  function automatic void build_order();
    int r, c;
    bit up;
    r = 0; c = 0; up = 1'b1;
    for (int k = 0; k < 64; k++) begin
      order[k] = r * 8 + c;
      if (up) begin
        if (c == 7) begin r++; up = 1'b0; end
        else if (r == 0) begin c++; up = 1'b0; end
        else begin r--; c++; end
      end else begin
        if (r == 7) begin c++; up = 1'b1; end
        else if (c == 0) begin r++; up = 1'b1; end
        else begin r++; c--; end
      end
    end
  endfunction

  task automatic expect_block(input logic [CW-1:0] b [64]);
    int lastk, run;
    lastk = -1; run = 0;
    for (int k = 0; k < 64; k++) if (b[order[k]] != '0) lastk = k;
    if (lastk < 0) expq.push_back({1'b1, 3'(bblk), 6'd0, {CW{1'b0}}});
    for (int k = 0; k <= lastk; k++) begin
      if (b[order[k]] != '0) begin
        expq.push_back({k == lastk, 3'(bblk), 6'(run), b[order[k]]});
        run = 0;
      end else run++;
    end
    bblk = (bblk == 5) ? 0 : bblk + 1;
  endtask

  task automatic send_block(input logic [CW-1:0] b [64], input int gap_pct);
    expect_block(b);
    for (int i = 0; i < 64; i++) begin
      // R2: idle cycles between accepted words
      while (gap_pct > 0 && int'($urandom_range(99)) < gap_pct) begin
        @(posedge clk); #1 in_vld = 1'b0;
      end
      @(posedge clk); #1 in_vld = 1'b1; in_coef = b[i];
    end
    @(posedge clk); #1 in_vld = 1'b0;
  endtask

  task automatic rand_block(output logic [CW-1:0] b [64], input int dens);
    for (int i = 0; i < 64; i++)
      b[i] = (int'($urandom_range(99)) < dens) ? CW'($urandom_range(1, (1 << CW) - 1)) : '0;
  endtask

  task automatic stream(input int nblk, input int gap_pct);
    logic [CW-1:0] b [64];
    for (int n = 0; n < nblk; n++) begin
      case (n % 9)
        0: for (int i = 0; i < 64; i++) b[i] = '0;
        1: for (int i = 0; i < 64; i++) b[i] = CW'(i + 1);
        2: begin for (int i = 0; i < 64; i++) b[i] = '0; b[63] = 8'h81; end
        3: begin for (int i = 0; i < 64; i++) b[i] = '0; b[0] = 8'h05; end
        4: begin for (int i = 0; i < 64; i++) b[i] = '0; b[7] = 8'hff; b[56] = 8'h01; end
        default: rand_block(b, int'($urandom_range(5, 60)));
      endcase
      expect_block(b);
      for (int i = 0; i < 64; i++) begin
        if (gap_pct > 0 && int'($urandom_range(99)) < gap_pct) begin
          @(posedge clk); #1 in_vld = 1'b0;
        end
        @(posedge clk); #1 in_vld = 1'b1; in_coef = b[i];
      end
    end
    @(posedge clk); #1 in_vld = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (150) @(posedge clk);
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL %s R9 R2: pending items actual=%0d expected=0", tag, expq.size());
      expq.delete();
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      total++;
      if (out_stb !== 1'b0 || out_val !== '1 || out_run !== '1 || out_eob !== 1'b0 || out_blk !== '1) begin
        bad++;
        $display("FAIL R1: reset outputs actual=%b_%h_%h_%b_%h expected=0_ff_3f_0_7",
                 out_stb, out_val, out_run, out_eob, out_blk);
      end
    end else if (out_stb === 1'b1) begin
      logic [IW-1:0] got, exp;
      got = {out_eob, out_blk, out_run, out_val};
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R3 R4 R9: extra item actual=%h expected=none", got);
      end else begin
        exp = expq.pop_front();
        if (got !== exp) begin
          bad++;
          $display("FAIL R3 R4 R5 R6 R7: item {eob,blk,run,val} actual=%h expected=%h", got, exp);
        end
      end
    end else begin
      total++;
      if (out_val !== '1 || out_run !== '1 || out_eob !== 1'b0 || out_blk !== '1) begin
        bad++;
        $display("FAIL R8: idle outputs actual=%h_%h_%b_%h expected=ff_3f_0_7",
                 out_val, out_run, out_eob, out_blk);
      end
    end
  end

  initial begin
    logic [CW-1:0] b [64];
    void'($urandom(32'd20240611));
    build_order();
    fork
      begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R3: single nonzero at raster 8 is scan position 2
        for (int i = 0; i < 64; i++) b[i] = '0;
        b[8] = 8'h3c;
        send_block(b, 0);
        // R6: all-zero sub-block
        for (int i = 0; i < 64; i++) b[i] = '0;
        send_block(b, 30);
        // R5: dense then sparse, gapped input
        rand_block(b, 90); send_block(b, 50);
        rand_block(b, 10); send_block(b, 20);
        drain("directed");
        // R9: back-to-back full-rate streaming
        stream(40, 0);
        drain("stream");
        stream(20, 25);
        drain("gapped");
        // R1 R7: mid-run reset restarts the sub-block index
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        bblk = 0;
        stream(13, 0);
        drain("after reset");
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R9: watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule